// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a programmable periodic interrupt from a 32.768 kHz timebase. A strobe input marks each timebase cycle and advances a 15-bit free-running count. A 4-bit rate code and an enable bit pick the period. When the count reaches a multiple of the selected period, a periodic event sets two flags in a status byte and raises an interrupt request line.

The count starts at zero at reset and is never restarted. A new rate therefore takes effect at the next boundary of the new period on that same count, and the first event does not wait a full period after the change. Rate code 0 turns events off. Codes 1 and 2 act as the slower codes 8 and 9. An acknowledge input clears the flags and the line, as a status read would. An inhibit input stops the line from rising but never stops it from falling.

Top module: `periodic_irq_gen`

## Requirements
- R1: After synchronous reset the status byte is 0x00, the interrupt line is low and the tick count is zero.
- R2: Rate code 0 produces no event, whatever the enable bit and the tick input do.
- R3: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks. These are the periods of codes 8 and 9.
- R4: For rate codes 3 to 15 the period is 2^(code-1) ticks, so it runs from 4 ticks up to 16384 ticks.
- R5: An event occurs on the tick that carries the count to a multiple of the period. The count is the number of ticks since reset, modulo 32768. Changing the rate does not reset the count.
- R6: While the enable input is low, no event occurs.
- R7: An event sets status bit 7 and status bit 6, leaves the other bits at 0, and raises the interrupt line. Both take effect on the clock edge that samples the boundary tick.
- R8: An acknowledge clears the status byte and lowers the line on the next edge. If an event falls on the same edge, the event wins and the flags are left set.
- R9: While inhibit is high, an event still sets the flags but does not raise the line. Inhibit does not prevent an acknowledge from lowering the line.
- R10: The count advances only on clocks where the tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-clock strobe for each 32.768 kHz timebase cycle |
| rate_sel | input | 4 | Rate code |
| pie_en | input | 1 | Periodic event enable |
| irq_inhibit | input | 1 | Blocks rising assertions of the interrupt line |
| status_ack | input | 1 | Clears the status flags and the line (read side effect) |
| status | output | 8 | Status byte: bit 7 is the any-interrupt flag, bit 6 is the periodic flag |
| irq_out | output | 1 | Interrupt request line |

## Verification
Status and the interrupt line are registered once after the boundary tick. The bench drives its inputs on the falling edge and samples on the next falling edge after the rising edge that acts on them. At that point its own tick counter has taken the same step as the design's counter, so the count at each event can be compared directly with a multiple of the period. An acknowledge shows its effect on the first falling edge after it is sampled. To test the same-edge race, the bench raises acknowledge in the tick just before a known boundary.

// File: rtl/pirg_pkg.sv
package pirg_pkg;

    localparam int CNT_W   = 15;   // free-running tick count width
    localparam int RATE_W  = 4;    // rate code width
    localparam int STAT_W  = 8;    // status byte width
    localparam int BIT_ANY = 7;    // any-interrupt flag position
    localparam int BIT_PER = 6;    // periodic flag position
    localparam int ALIAS_ADD = 7;  // codes 1 and 2 move up by this much

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic any_f;
        logic per_f;
    } flags_t;

    // Effective rate code after the low-code alias.
    function automatic rate_t eff_code(input rate_t code);
        if (code == rate_t'(1) || code == rate_t'(2))
            return code + rate_t'(ALIAS_ADD);
        return code;
    endfunction

endpackage

// File: rtl/pirg_divider.sv
module pirg_divider
    import pirg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output cnt_t cnt
);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + cnt_t'(1);
    end

    a_r10_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == $past(cnt) + cnt_t'(1));
    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pirg_rate_match.sv
module pirg_rate_match
    import pirg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  rate_t rate,
    input  logic  enable,
    input  cnt_t  cnt,
    output logic  event_o
);

    // ones[k] is high when count bits k..0 are all set.
    logic [CNT_W-1:0] ones;
    assign ones[0] = cnt[0];
    genvar k;
    generate
        for (k = 1; k < CNT_W; k++) begin : g_chain
            assign ones[k] = ones[k-1] & cnt[k];
        end
    endgenerate

    rate_t eff;
    logic  hit;
    always_comb begin
        eff = eff_code(rate);
        hit = 1'b0;
        // Period 2^(eff-1): the next tick reaches a boundary when the low eff-1 bits are all set.
        if (eff >= rate_t'(3))
            hit = ones[int'(eff) - 2];
        event_o = tick && enable && hit;
    end

    a_r2_code0_silent: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |-> !event_o);
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !event_o);
    a_r5_boundary_next: assert property (@(posedge clk) disable iff (rst)
        (event_o && rate == rate_t'(3)) |=> (cnt[1:0] == 2'b00));

endmodule

// File: rtl/pirg_flags.sv
module pirg_flags
    import pirg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   event_i,
    input  logic   ack,
    input  logic   inhibit,
    output flags_t flags,
    output logic   irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else if (event_i) begin
            flags <= '{any_f: 1'b1, per_f: 1'b1};
            if (!inhibit) irq <= 1'b1;
        end else if (ack) begin
            flags <= '0;
            irq   <= 1'b0;
        end
    end

    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
        event_i |=> (flags.any_f && flags.per_f));
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !event_i) |=> (flags == '0 && !irq));
    a_r9_no_rise_inhibited: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(inhibit));

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pirg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              irq_inhibit,
    input  logic              status_ack,
    output logic [STAT_W-1:0] status,
    output logic              irq_out
);

    cnt_t   cnt;
    logic   ev;
    flags_t flags;

    pirg_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_32k),
        .cnt  (cnt)
    );

    pirg_rate_match u_match (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_32k),
        .rate    (rate_sel),
        .enable  (pie_en),
        .cnt     (cnt),
        .event_o (ev)
    );

    pirg_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .event_i (ev),
        .ack     (status_ack),
        .inhibit (irq_inhibit),
        .flags   (flags),
        .irq     (irq_out)
    );

    always_comb begin
        status          = '0;
        status[BIT_ANY] = flags.any_f;
        status[BIT_PER] = flags.per_f;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq_out));

endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = '0;
    logic       pie_en = 1'b0;
    logic       irq_inhibit = 1'b0;
    logic       status_ack = 1'b0;
    logic [7:0] status;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    int tick_div = 1;   // 0 stops ticks
    int ph = 0;
    logic [14:0] tcnt = '0;   // bench count of ticks since reset
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periodic_irq_gen dut (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .pie_en(pie_en), .irq_inhibit(irq_inhibit), .status_ack(status_ack),
        .status(status), .irq_out(irq_out)
    );

    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick_32k <= 1'b0;
            ph <= 0;
        end else begin
            tick_32k <= (ph == 0);
            ph <= (ph + 1 >= tick_div) ? 0 : ph + 1;
        end
    end

    always @(posedge clk) begin
        if (rst)           tcnt <= '0;
        else if (tick_32k) tcnt <= tcnt + 15'd1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int code);
        int e;
        e = (code == 1 || code == 2) ? code + 7 : code;
        return 1 << (e - 1);
    endfunction

    task automatic ack_pulse();
        status_ack = 1'b1;
        @(negedge clk);
        status_ack = 1'b0;
    endtask

    // Waits at falling edges until the periodic flag shows.
    task automatic wait_flag(input int limit, output bit found);
        found = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (status[6]) begin found = 1; return; end
        end
    endtask

    initial begin
        bit f;
        int t1, t2, p;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 8'h00, "R1 status", status, 0);
        chk(irq_out == 1'b0, "R1 irq", irq_out, 0);
        rst = 1'b0;

        // R2 code 0 silent with enable high
        rate_sel = 4'd0; pie_en = 1'b1;
        repeat (300) @(negedge clk);
        chk(status == 8'h00 && !irq_out, "R2 code0", status, 0);

        // R6 enable low silent
        rate_sel = 4'd3; pie_en = 1'b0;
        repeat (100) @(negedge clk);
        chk(status == 8'h00 && !irq_out, "R6 disabled", status, 0);

        // R3 R4 R5 R7 sweep all nonzero codes, tick every clock
        for (int c = 1; c < 16; c++) begin
            p = period_of(c);
            rate_sel = c[3:0]; pie_en = 1'b1;
            ack_pulse();
            @(negedge clk);
            if (status[6]) ack_pulse();
            wait_flag(2 * p + 8, f);
            t1 = int'(tcnt);
            chk(f && status == 8'hC0 && irq_out, (c < 3) ? "R3 R7 first event" : "R4 R7 first event", status, 8'hC0);
            chk(t1 % p == 0, "R5 boundary", t1 % p, 0);
            ack_pulse();
            wait_flag(p + 8, f);
            t2 = int'(tcnt);
            chk(f && ((t2 - t1 + 32768) % 32768) == p, (c < 3) ? "R3 period" : "R4 period",
                (t2 - t1 + 32768) % 32768, p);
            ack_pulse();
        end

        // R8 acknowledge clears
        rate_sel = 4'd3;
        wait_flag(20, f);
        ack_pulse();
        chk(status == 8'h00 && !irq_out, "R8 ack clears", status, 0);

        // R8 event and ack on the same edge: event wins
        while (tcnt % 4 != 3) @(negedge clk);
        status_ack = 1'b1;
        @(negedge clk);
        status_ack = 1'b0;
        chk(status == 8'hC0, "R8 event wins", status, 8'hC0);
        ack_pulse();

        // R9 inhibit blocks rise, flags still set
        irq_inhibit = 1'b1;
        @(negedge clk);
        if (status[6]) ack_pulse();
        wait_flag(20, f);
        chk(f && status == 8'hC0, "R9 flags while inhibited", status, 8'hC0);
        chk(irq_out == 1'b0, "R9 no rise", irq_out, 0);
        // R9 inhibit does not block deassert
        irq_inhibit = 1'b0;
        ack_pulse();
        wait_flag(20, f);
        chk(irq_out == 1'b1, "R9 raised uninhibited", irq_out, 1);
        irq_inhibit = 1'b1;
        pie_en = 1'b0;
        ack_pulse();
        chk(irq_out == 1'b0, "R9 ack lowers inhibited", irq_out, 0);
        irq_inhibit = 1'b0;

        // R10 no ticks, no progress
        tick_div = 0;
        pie_en = 1'b1;
        repeat (2) @(negedge clk);
        ack_pulse();
        repeat (60) @(negedge clk);
        chk(status == 8'h00, "R10 frozen", status, 0);

        // R5 R10 slower tick, rate change mid-run keeps the count
        tick_div = 3; rate_sel = 4'd5;
        wait_flag(200, f);
        ack_pulse();
        repeat (6) @(negedge clk);
        rate_sel = 4'd4;
        wait_flag(40, f);
        chk(f && (int'(tcnt) % 8 == 0), "R5 rate change boundary", int'(tcnt) % 8, 0);
        chk(int'(tcnt) % 16 == 8, "R5 count not restarted", int'(tcnt) % 16, 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule